// File: doc/BRIEF.md
# Bus-Mapped Parallel Printer Port

This block lets a processor drive an 8-bit parallel printer through four bus addresses. The processor talks to it with a four-phase handshake. It raises `ready_i` with `cs_i` high and a valid address. The port answers with `accept_o` and keeps it high until the processor drops `ready_i`. The processor may then start a new cycle once `accept_o` is low again.

Writing a byte to the data register starts a transfer on the printer side. First the port waits for the printer to leave its busy state. It then sets the byte up on the printer data lines, pulses the active-low strobe, and waits for the printer's active-low acknowledge pulse to go low and return high. The data lines hold the byte for the whole transfer. A status register reports the transfer state.

All handshake inputs from both sides pass through two-flop synchronizers into the single system clock.

Top module: `prn_port_top`

## Requirements
- R1: After reset, `accept_o` is 0, `strobe_no` is 1, `pdata_o` is 0 and `rdata_o` is 0.
- R2: The port answers only when `addr_i` is in 0xBEEC..0xBEEF. For any other address, `accept_o` stays 0 even while `ready_i` and `cs_i` are high.
- R3: `accept_o` rises only after `ready_i` and `cs_i` are both high, stays high while `ready_i` is high, and falls after `ready_i` falls.
- R4: A write (`rd_nwr_i`=0) to offset 0 (address 0xBEEC) while no transfer is pending puts the written byte on `pdata_o`.
- R5: A read (`rd_nwr_i`=1) of offset 1 (address 0xBEED) returns a status byte. Bit0 is transfer pending, bit1 is the synchronized printer busy level, bit2 is acknowledge seen for the last transfer, and bits 7..3 are 0.
- R6: Reads of offsets 0, 2 and 3 return 0. Writes to offsets 2 and 3 are accepted but start no transfer.
- R7: While `pbusy_i` is high, no strobe is started. The strobe follows once busy goes low.
- R8: `pdata_o` holds the new byte for at least 2 clocks before `strobe_no` falls, and `strobe_no` stays low for exactly 4 clocks.
- R9: `pdata_o` stays stable and status bit0 stays 1 until the printer's acknowledge has gone low and returned high. Bit2 is then 1, and it clears when the next transfer starts.
- R10: A data write while a transfer is pending is accepted, but the byte is discarded and the running transfer carries on unchanged.
- R11: With `cs_i` low, `ready_i` has no effect and `accept_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ready_i | input | 1 | processor cycle request, asynchronous |
| cs_i | input | 1 | chip select, asynchronous |
| rd_nwr_i | input | 1 | 1 read, 0 write |
| addr_i | input | 16 | processor address |
| wdata_i | input | 8 | processor write data |
| rdata_o | output | 8 | processor read data, valid while accept_o is high |
| accept_o | output | 1 | handshake answer to the processor |
| pdata_o | output | 8 | printer data lines |
| strobe_no | output | 1 | data strobe to the printer, active low |
| pack_ni | input | 1 | printer acknowledge, active low, asynchronous |
| pbusy_i | input | 1 | printer busy, asynchronous |

## Verification
The hardest case to reach is a second data write that arrives while the first byte is still waiting for the printer's acknowledge. The bench's printer model answers the strobe only after a long, configurable delay. The processor write therefore lands in the acknowledge-wait window, and the bench checks that the printer lines and the strobe count show only the first byte. Holding the busy line high across a write likewise parks the sequencer before its strobe, so the status bits can be read in that state.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 16'hBEEC;
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WBUSY, SQ_SETUP, SQ_STRB, SQ_ACKL, SQ_ACKH
  } seq_st_e;

  typedef enum logic {BS_IDLE, BS_ACK} bus_st_e;
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] m_q, s_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= RST_VAL;
      s_q <= RST_VAL;
    end else begin
      m_q <= d_i;
      s_q <= m_q;
    end
  end
  assign q_o = s_q;
endmodule

// File: rtl/prn_bus_if.sv
module prn_bus_if
  import prn_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [AW-1:0] BASE = BASE_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_s_i,
  input  logic          cs_s_i,
  input  logic          rd_nwr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  input  logic          busy_i,
  output logic          accept_o,
  output logic [DW-1:0] rdata_o,
  output logic          start_o,
  output logic [DW-1:0] byte_o
);
  bus_st_e      st_q;
  logic         accept_q, start_q;
  logic [DW-1:0] rdata_q, byte_q, rd_sel;
  logic         hit;
  logic [1:0]   off;

  assign hit = (addr_i[AW-1:2] == BASE[AW-1:2]);
  assign off = addr_i[1:0];

  always_comb begin
    unique case (off)
      OFF_STAT: rd_sel = status_i;
      default:  rd_sel = '0;
    endcase
  end

  // addr/data/dir are stable by protocol once synced ready is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= BS_IDLE;
      accept_q <= 1'b0;
      start_q  <= 1'b0;
      rdata_q  <= '0;
      byte_q   <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        BS_IDLE: if (ready_s_i && cs_s_i && hit) begin
          accept_q <= 1'b1;
          st_q     <= BS_ACK;
          if (rd_nwr_i) rdata_q <= rd_sel;
          else if (off == OFF_DATA && !busy_i && !start_q) begin
            start_q <= 1'b1;
            byte_q  <= wdata_i;
          end
        end
        BS_ACK: if (!ready_s_i) begin
          accept_q <= 1'b0;
          st_q     <= BS_IDLE;
        end
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign accept_o = accept_q;
  assign rdata_o  = rdata_q;
  assign start_o  = start_q;
  assign byte_o   = byte_q;

  a_r3_accept_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_q && ready_s_i) |=> accept_q);
  a_r3_accept_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(accept_q) |-> !$past(ready_s_i));
  a_r11_accept_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_q) |-> $past(cs_s_i && ready_s_i));
endmodule

// File: rtl/prn_seq.sv
module prn_seq
  import prn_pkg::*;
#(
  parameter int unsigned DW        = DATA_W,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned STRB_CYC  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] byte_i,
  input  logic          busy_s_i,
  input  logic          ack_s_ni,
  output logic [DW-1:0] pdata_o,
  output logic          strobe_no,
  output logic          pending_o,
  output logic          ack_seen_o
);
  localparam int unsigned MAXC  = (SETUP_CYC > STRB_CYC) ? SETUP_CYC : STRB_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STRB_LAST  = CNT_W'(STRB_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0] pdata_q;
  logic          strobe_q, ack_seen_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (start_i) st_d = SQ_WBUSY;
      SQ_WBUSY: if (!busy_s_i) st_d = SQ_SETUP;
      SQ_SETUP: if (cnt_q == SETUP_LAST) st_d = SQ_STRB;
      SQ_STRB:  if (cnt_q == STRB_LAST) st_d = SQ_ACKL;
      SQ_ACKL:  if (!ack_s_ni) st_d = SQ_ACKH;
      SQ_ACKH:  if (ack_s_ni) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      cnt_q      <= '0;
      pdata_q    <= '0;
      strobe_q   <= 1'b1;
      ack_seen_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      strobe_q <= (st_d != SQ_STRB);
      cnt_q    <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
      if (st_q == SQ_IDLE && start_i) begin
        pdata_q    <= byte_i;
        ack_seen_q <= 1'b0;
      end
      if (st_q == SQ_ACKL && !ack_s_ni) ack_seen_q <= 1'b1;
    end
  end

  assign pdata_o    = pdata_q;
  assign strobe_no  = strobe_q;
  assign pending_o  = (st_q != SQ_IDLE);
  assign ack_seen_o = ack_seen_q;

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SQ_IDLE && $past(st_q) != SQ_IDLE) |-> $stable(pdata_q));
  a_r7_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_WBUSY && busy_s_i) |=> strobe_q);
  a_r8_strobe_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q) |=> !strobe_q);
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_ACKL) |=> (st_q == SQ_ACKL || st_q == SQ_ACKH));
endmodule

// File: rtl/prn_port_top.sv
module prn_port_top
  import prn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              cs_i,
  input  logic              rd_nwr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              accept_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic              strobe_no,
  input  logic              pack_ni,
  input  logic              pbusy_i
);
  logic ready_s, cs_s, busy_s, ack_s_n;
  logic start, pending, ack_seen;
  logic [DATA_W-1:0] start_byte, status;

  prn_sync #(.W(2), .RST_VAL(2'b00)) u_sync_cpu (
    .clk_i, .rst_ni, .d_i({ready_i, cs_i}), .q_o({ready_s, cs_s}));
  prn_sync #(.W(2), .RST_VAL(2'b01)) u_sync_prn (
    .clk_i, .rst_ni, .d_i({pbusy_i, pack_ni}), .q_o({busy_s, ack_s_n}));

  assign status = {{(DATA_W-3){1'b0}}, ack_seen, busy_s, pending};

  prn_bus_if u_bus (
    .clk_i, .rst_ni,
    .ready_s_i(ready_s), .cs_s_i(cs_s), .rd_nwr_i, .addr_i, .wdata_i,
    .status_i(status), .busy_i(pending),
    .accept_o, .rdata_o, .start_o(start), .byte_o(start_byte));

  prn_seq u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .byte_i(start_byte),
    .busy_s_i(busy_s), .ack_s_ni(ack_s_n),
    .pdata_o, .strobe_no, .pending_o(pending), .ack_seen_o(ack_seen));
endmodule

// File: tb/prn_port_top_tb.sv
`timescale 1ns/1ps
module prn_port_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ready = 1'b0, cs = 1'b0, rd = 1'b0, pack_n = 1'b1, pbusy = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, pdata;
  logic        accept, strobe_n;
  int total = 0, bad = 0;
  int ack_delay = 3;
  int slow = 0, last_w = 0, nstrobes = 0, setup_cnt = 0, last_setup = 0;
  logic [7:0] got_byte = '0, prev_pdata = '0;
  logic prev_strobe = 1'b1;

  always #4 clk = ~clk;

  prn_port_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .cs_i(cs), .rd_nwr_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .accept_o(accept),
    .pdata_o(pdata), .strobe_no(strobe_n), .pack_ni(pack_n), .pbusy_i(pbusy));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // printer-side monitor
  always @(negedge clk) begin
    if (pdata !== prev_pdata) setup_cnt = 0;
    if (!strobe_n) begin
      if (prev_strobe) begin last_setup = setup_cnt; got_byte = pdata; end
      slow++;
    end else begin
      setup_cnt++;
      if (slow != 0) begin last_w = slow; slow = 0; nstrobes++; end
    end
    prev_strobe = strobe_n;
    prev_pdata  = pdata;
  end

  // printer model: ack pulse after strobe ends
  initial begin
    forever begin
      do @(negedge clk); while (strobe_n);
      do @(negedge clk); while (!strobe_n);
      repeat (ack_delay) @(negedge clk);
      pack_n = 1'b0;
      repeat (3) @(negedge clk);
      pack_n = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  task automatic bus(input logic [15:0] a, input logic r, input logic [7:0] d,
                     output logic ok, output logic [7:0] q);
    @(negedge clk);
    addr = a; rd = r; wdata = d; cs = 1'b1; ready = 1'b1; ok = 1'b0; q = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (accept) begin ok = 1'b1; break; end
    end
    q = rdata;
    if (ok) begin
      repeat (3) @(negedge clk);
      chk("R3 accept held while ready", accept, 1);
    end
    ready = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!accept) break;
    end
    if (ok) chk("R3 accept drops after ready", accept, 0);
    cs = 1'b0;
  endtask

  task automatic wait_idle();
    logic ok; logic [7:0] q;
    for (int i = 0; i < 100; i++) begin
      bus(16'hBEED, 1'b1, 8'h00, ok, q);
      if (!q[0]) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 accept", accept, 0);
    chk("R1 strobe", strobe_n, 1);
    chk("R1 pdata", pdata, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_decode();
    logic ok; logic [7:0] q;
    bus(16'hBEEB, 1'b0, 8'h11, ok, q);
    chk("R2 below window", ok, 0);
    bus(16'hBEF0, 1'b0, 8'h11, ok, q);
    chk("R2 above window", ok, 0);
    bus(16'h3EEC, 1'b0, 8'h11, ok, q);
    chk("R2 high bit differs", ok, 0);
    chk("R2 no strobe", nstrobes, 0);
    bus(16'hBEEF, 1'b1, 8'h00, ok, q);
    chk("R2 top of window", ok, 1);
  endtask

  task automatic t_cs();
    @(negedge clk);
    addr = 16'hBEEC; rd = 1'b0; wdata = 8'h77; cs = 1'b0; ready = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 accept with cs low", accept, 0);
    ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no transfer", nstrobes, 0);
  endtask

  task automatic t_write_basic();
    logic ok; logic [7:0] q;
    int n0 = nstrobes;
    bus(16'hBEEC, 1'b0, 8'h5A, ok, q);
    chk("R3 write accepted", ok, 1);
    chk("R4 byte on printer bus", pdata, 8'h5A);
    for (int i = 0; i < 50 && nstrobes == n0; i++) @(negedge clk);
    chk("R8 strobe width", last_w, 4);
    chk("R8 setup >= 2", (last_setup >= 2), 1);
    chk("R4 byte at strobe", got_byte, 8'h5A);
    wait_idle();
    bus(16'hBEED, 1'b1, 8'h00, ok, q);
    chk("R9 ack seen, idle", q, 8'h04);
    chk("R9 pdata kept", pdata, 8'h5A);
  endtask

  task automatic t_busy();
    logic ok; logic [7:0] q;
    int n0;
    pbusy = 1'b1;
    repeat (4) @(negedge clk);
    n0 = nstrobes;
    bus(16'hBEEC, 1'b0, 8'hC3, ok, q);
    repeat (30) @(negedge clk);
    chk("R7 no strobe while busy", nstrobes, n0);
    chk("R7 strobe high", strobe_n, 1);
    bus(16'hBEED, 1'b1, 8'h00, ok, q);
    chk("R5 status pending+busy, ack cleared", q, 8'h03);
    pbusy = 1'b0;
    for (int i = 0; i < 50 && nstrobes == n0; i++) @(negedge clk);
    chk("R7 strobe after busy low", nstrobes, n0 + 1);
    chk("R7 byte", got_byte, 8'hC3);
    wait_idle();
    bus(16'hBEED, 1'b1, 8'h00, ok, q);
    chk("R5 status done", q, 8'h04);
  endtask

  task automatic t_offsets();
    logic ok; logic [7:0] q;
    int n0 = nstrobes;
    bus(16'hBEEE, 1'b0, 8'hFF, ok, q);
    chk("R6 write off2 accepted", ok, 1);
    bus(16'hBEEF, 1'b0, 8'hEE, ok, q);
    repeat (20) @(negedge clk);
    chk("R6 no transfer", nstrobes, n0);
    chk("R6 pdata untouched", pdata, 8'hC3);
    bus(16'hBEEE, 1'b1, 8'h00, ok, q);
    chk("R6 read off2", q, 0);
    bus(16'hBEEF, 1'b1, 8'h00, ok, q);
    chk("R6 read off3", q, 0);
    bus(16'hBEEC, 1'b1, 8'h00, ok, q);
    chk("R6 read off0", q, 0);
    bus(16'hBEED, 1'b1, 8'h00, ok, q);
    chk("R6 status pending clear", q[0], 0);
  endtask

  task automatic t_overrun();
    logic ok; logic [7:0] q;
    int n0 = nstrobes;
    ack_delay = 60;
    bus(16'hBEEC, 1'b0, 8'hA5, ok, q);
    for (int i = 0; i < 50 && nstrobes == n0; i++) @(negedge clk);
    bus(16'hBEED, 1'b1, 8'h00, ok, q);
    chk("R9 pending until ack", q, 8'h01);
    bus(16'hBEEC, 1'b0, 8'h33, ok, q);
    chk("R10 late write accepted", ok, 1);
    chk("R10 pdata kept", pdata, 8'hA5);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R10 single strobe", nstrobes, n0 + 1);
    chk("R10 byte", got_byte, 8'hA5);
    chk("R10 pdata final", pdata, 8'hA5);
    ack_delay = 3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_decode();
    t_cs();
    t_write_basic();
    t_busy();
    t_offsets();
    t_overrun();
    report();
  end
endmodule